// File: doc/BRIEF.md
# Programmable PLL Divider Chain

This block is the digital divider path that sits around a frequency-synthesis loop. A reference divider brings the input clock down to the comparison frequency. A feedback divider brings the fast oscillator clock down to the same rate. A post scaler derives the delivered clock from the fast oscillator clock. When the loop is locked, the delivered frequency is m·Fin/(p·s). The phase detector, charge pump, filter and oscillator are outside the block. In use, the fast clock comes straight from the oscillator.

A single 16-bit setting word carries all three ratios. Each field is offset-encoded: the reference ratio is the field plus 2, the feedback ratio is the field plus 8, and the post ratio is two to the power of the field. The word lives in a register that software writes through a write strobe. A test select can replace a build-time subset of its bits with externally driven values.

A power-down input stops every divided clock. The clocks restart cleanly when it is released. Each divider is a down-counter with a small two-state machine. In HALT the counter is cleared and the output is held low. In RUN the counter decrements, and at terminal count it latches the current ratio again. There are three transitions. HALT→RUN is taken when the synchronized run level rises. RUN→RUN either reloads (at terminal count) or decrements. RUN→HALT is taken when the run level falls.

Top module: `pll_div_chain`

## Requirements
- R1: `ref_div_o` has a period of P+2 `ref_clk` cycles, where P is setting-word bits [5:0].
- R2: `fb_div_o` has a period of M+8 `fast_clk` cycles, where M is setting-word bits [13:6].
- R3: `clk_out` has a period of 2^S `fast_clk` cycles, where S is setting-word bits [15:14]. S=0 passes the fast clock through.
- R4: The setting register takes `cfg_wdata` on a `fast_clk` rising edge when `cfg_we` is 1. With `cfg_we` at 0, it keeps its value whatever `cfg_wdata` carries.
- R5: While `rst_n` is low, all three outputs are low and the register is cleared to zero. After release with no write, the ratios are therefore 2, 8 and 1.
- R6: While `tst_sel` is 1, each setting-word bit that is set in BYPASS_MASK is taken from `tst_bits`. The default mask is 0xC03F, which covers the S and P fields. All other bits still come from the register.
- R7: Once `pwr_down` has been high for SYNC_STAGES+2 cycles of a clock domain, that domain's outputs stay low. After release, `fb_div_o` stays low across two `fast_clk` rising edges and goes high on the third, which starts a fresh period.
- R8: A ratio written while a divider is counting takes effect only at that divider's next reload. The period already in progress completes at the old length.
- R9: The `clk_out` duty cycle is 50%, and at least within 40% to 60%, for every S value including divide-by-one.
- R10: Within each period of N cycles, the reference and feedback outputs are high for ceil(N/2) cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fast_clk | input | 1 | Fast oscillator clock; feeds the feedback divider, the post scaler and the setting register |
| ref_clk | input | 1 | Reference input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | High stops all divided clocks |
| cfg_we | input | 1 | Setting-register write strobe |
| cfg_wdata | input | 16 | Setting word to write: {S, M, P} |
| tst_sel | input | 1 | Selects the test bypass for the masked bits |
| tst_bits | input | 16 | Externally driven setting bits used under test bypass |
| ref_div_o | output | 1 | Divided reference clock |
| fb_div_o | output | 1 | Divided feedback clock |
| clk_out | output | 1 | Scaled output clock |

## Verification
The bench builds the block with its default parameters: 6-, 8- and 2-bit fields, offsets 2 and 8, two synchronizer stages, and a bypass mask over the S and P fields. At these widths the largest ratios (65, 263 and 8) fit in windows of a few hundred cycles. That puts the extreme field values, the smallest ratios and divide-by-one all within reach. The mask splits the word into overridden and protected fields, so a single bypass run shows both a substituted field and a field the test bits cannot touch.

// File: rtl/pdc_pkg.sv
`timescale 1ns/1ps
package pdc_pkg;

    // Default field widths and ratio offsets of the setting word {S, M, P}.
    localparam int PDC_P_W   = 6;
    localparam int PDC_M_W   = 8;
    localparam int PDC_S_W   = 2;
    localparam int PDC_P_OFS = 2;
    localparam int PDC_M_OFS = 8;

    // Divider control states.
    typedef enum logic {
        DV_HALT = 1'b0,
        DV_RUN  = 1'b1
    } dv_state_e;

endpackage

// File: rtl/pdc_sync.sv
`timescale 1ns/1ps
// Level synchronizer; resets to the "halted" level (all ones).
module pdc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shift_q <= '1;
        else        shift_q <= {shift_q[STAGES-2:0], d};
    end

    assign q = shift_q[STAGES-1];
endmodule

// File: rtl/pdc_cfg_reg.sv
`timescale 1ns/1ps
// Setting-word register, cleared by reset, loaded on write strobe.
module pdc_cfg_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata;
    end
endmodule

// File: rtl/pdc_divider.sv
`timescale 1ns/1ps
// Reloading down-counter divider with a HALT/RUN control machine.
// ALLOW_ONE selects a variant that can also pass the clock through (ratio 1).
module pdc_divider
    import pdc_pkg::*;
#(
    parameter int CW        = 8,
    parameter bit ALLOW_ONE = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] ratio_i,
    output logic          clk_o
);
    dv_state_e     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] lat_q, lat_d;
    logic          div_q, div_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= DV_HALT;
        else        st_q <= st_d;
    end

    // Transitions: HALT->RUN on run, RUN->HALT on !run, RUN->RUN otherwise
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DV_HALT: if (run)  st_d = DV_RUN;
            DV_RUN:  if (!run) st_d = DV_HALT;
            default: st_d = DV_HALT;
        endcase
    end

    // Counter and ratio latch: a new ratio is taken only at reload
    always_comb begin
        cnt_d = '0;
        lat_d = '0;
        unique case (st_q)
            DV_HALT: begin
                if (run) begin
                    lat_d = ratio_i;
                    cnt_d = ratio_i - CW'(1);
                end
            end
            DV_RUN: begin
                if (run) begin
                    if (cnt_q == '0) begin
                        lat_d = ratio_i;
                        cnt_d = ratio_i - CW'(1);
                    end else begin
                        lat_d = lat_q;
                        cnt_d = cnt_q - CW'(1);
                    end
                end
            end
            default: ;
        endcase
        div_d = run && (lat_d != CW'(1)) && (cnt_d >= (lat_d >> 1));
    end

    // Output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lat_q <= '0;
            div_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            lat_q <= lat_d;
            div_q <= div_d;
        end
    end

    generate
        if (ALLOW_ONE) begin : g_gate
            logic one_q;
            logic gate_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) one_q <= 1'b0;
                else        one_q <= (lat_d == CW'(1));
            end
            // Enable changes only while the clock is low.
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) gate_q <= 1'b0;
                else        gate_q <= one_q;
            end
            assign clk_o = (clk & gate_q) | div_q;
        end else begin : g_plain
            assign clk_o = div_q;
        end
    endgenerate
endmodule

// File: rtl/pll_div_chain.sv
`timescale 1ns/1ps
module pll_div_chain
    import pdc_pkg::*;
#(
    parameter int P_W         = PDC_P_W,
    parameter int M_W         = PDC_M_W,
    parameter int S_W         = PDC_S_W,
    parameter int P_OFS       = PDC_P_OFS,
    parameter int M_OFS       = PDC_M_OFS,
    parameter int SYNC_STAGES = 2,
    parameter logic [P_W+M_W+S_W-1:0] BYPASS_MASK = 16'hC03F
) (
    input  logic                   fast_clk,
    input  logic                   ref_clk,
    input  logic                   rst_n,
    input  logic                   pwr_down,
    input  logic                   cfg_we,
    input  logic [P_W+M_W+S_W-1:0] cfg_wdata,
    input  logic                   tst_sel,
    input  logic [P_W+M_W+S_W-1:0] tst_bits,
    output logic                   ref_div_o,
    output logic                   fb_div_o,
    output logic                   clk_out
);
    localparam int WORD_W = P_W + M_W + S_W;
    localparam int P_RW   = P_W + 1;
    localparam int M_RW   = M_W + 1;
    localparam int S_RW   = 2 ** S_W;

    logic [WORD_W-1:0] cfg_q;
    logic [WORD_W-1:0] eff_word;
    logic [P_W-1:0]    p_fld;
    logic [M_W-1:0]    m_fld;
    logic [S_W-1:0]    s_fld;
    logic [P_RW-1:0]   ref_ratio;
    logic [M_RW-1:0]   fb_ratio;
    logic [S_RW-1:0]   post_ratio;
    logic              halt_fast, halt_ref;

    pdc_cfg_reg #(.W(WORD_W)) u_cfg (
        .clk   (fast_clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .q     (cfg_q)
    );

    // Test bypass: masked bits come from the test inputs
    assign eff_word = tst_sel ? ((cfg_q & ~BYPASS_MASK) | (tst_bits & BYPASS_MASK))
                              : cfg_q;

    assign p_fld = eff_word[P_W-1:0];
    assign m_fld = eff_word[P_W +: M_W];
    assign s_fld = eff_word[P_W+M_W +: S_W];

    assign ref_ratio  = {1'b0, p_fld} + P_RW'(P_OFS);
    assign fb_ratio   = {1'b0, m_fld} + M_RW'(M_OFS);
    assign post_ratio = S_RW'(1) << s_fld;

    pdc_sync #(.STAGES(SYNC_STAGES)) u_sync_fast (
        .clk   (fast_clk),
        .rst_n (rst_n),
        .d     (pwr_down),
        .q     (halt_fast)
    );

    pdc_sync #(.STAGES(SYNC_STAGES)) u_sync_ref (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d     (pwr_down),
        .q     (halt_ref)
    );

    pdc_divider #(.CW(P_RW), .ALLOW_ONE(1'b0)) u_ref_div (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .run     (!halt_ref),
        .ratio_i (ref_ratio),
        .clk_o   (ref_div_o)
    );

    pdc_divider #(.CW(M_RW), .ALLOW_ONE(1'b0)) u_fb_div (
        .clk     (fast_clk),
        .rst_n   (rst_n),
        .run     (!halt_fast),
        .ratio_i (fb_ratio),
        .clk_o   (fb_div_o)
    );

    pdc_divider #(.CW(S_RW), .ALLOW_ONE(1'b1)) u_post (
        .clk     (fast_clk),
        .rst_n   (rst_n),
        .run     (!halt_fast),
        .ratio_i (post_ratio),
        .clk_o   (clk_out)
    );
endmodule

// File: rtl/pdc_checker.sv
`timescale 1ns/1ps
module pdc_checker #(
    parameter int SYNC_STAGES = 2,
    parameter int WORD_W      = 16,
    parameter int FB_HI_MAX   = 132
) (
    input logic              fast_clk,
    input logic              ref_clk,
    input logic              rst_n,
    input logic              pwr_down,
    input logic              cfg_we,
    input logic [WORD_W-1:0] cfg_q,
    input logic              ref_div_o,
    input logic              fb_div_o,
    input logic              clk_out
);
    localparam int SAT = SYNC_STAGES + 4;

    logic [7:0]  pdf_q, pdr_q, quiet_q;
    logic [15:0] hi_q;

    always_ff @(posedge fast_clk or negedge rst_n) begin
        if (!rst_n) begin
            pdf_q   <= '0;
            quiet_q <= '0;
            hi_q    <= '0;
        end else begin
            pdf_q   <= !pwr_down ? 8'd0 : (pdf_q < 8'(SAT) ? pdf_q + 8'd1 : pdf_q);
            quiet_q <= pwr_down ? 8'd0 : (quiet_q < 8'(SAT) ? quiet_q + 8'd1 : quiet_q);
            hi_q    <= !fb_div_o ? 16'd0 : (hi_q < 16'hFFFF ? hi_q + 16'd1 : hi_q);
        end
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) pdr_q <= '0;
        else        pdr_q <= !pwr_down ? 8'd0 : (pdr_q < 8'(SAT) ? pdr_q + 8'd1 : pdr_q);
    end

    // R4: register keeps its value without a write strobe
    p_cfg_hold_r4: assert property (@(posedge fast_clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_q));

    // R7: fast-domain outputs low after power-down settles
    p_fast_halt_low_r7: assert property (@(posedge fast_clk) disable iff (!rst_n)
        (pdf_q >= 8'(SYNC_STAGES + 2)) |-> (!fb_div_o && !clk_out));

    // R7: reference-domain output low after power-down settles
    p_ref_halt_low_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (pdr_q >= 8'(SYNC_STAGES + 2)) |-> !ref_div_o);

    // R10: feedback high phase lasts at least two cycles (ratio >= 8)
    p_fb_high_min_r10: assert property (@(posedge fast_clk) disable iff (!rst_n)
        ($rose(fb_div_o) && (quiet_q >= 8'(SYNC_STAGES + 3))) |=> fb_div_o);

    // R2: feedback high phase never exceeds half the largest ratio
    p_fb_high_max_r2: assert property (@(posedge fast_clk) disable iff (!rst_n)
        hi_q <= 16'(FB_HI_MAX));
endmodule

bind pll_div_chain pdc_checker #(
    .SYNC_STAGES (SYNC_STAGES),
    .WORD_W      (P_W + M_W + S_W),
    .FB_HI_MAX   (((1 << M_W) + M_OFS) / 2)
) u_chk (
    .fast_clk  (fast_clk),
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .pwr_down  (pwr_down),
    .cfg_we    (cfg_we),
    .cfg_q     (cfg_q),
    .ref_div_o (ref_div_o),
    .fb_div_o  (fb_div_o),
    .clk_out   (clk_out)
);

// File: tb/pll_div_chain_test.sv
`timescale 1ns/1ps
module pll_div_chain_test;
    logic        fast_clk = 1'b0;
    logic        ref_clk  = 1'b0;
    logic        rst_n    = 1'b0;
    logic        pwr_down = 1'b0;
    logic        cfg_we   = 1'b0;
    logic        tst_sel  = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] tst_bits  = '0;
    wire         ref_div_o, fb_div_o, clk_out;

    int n_cmp = 0;
    int n_bad = 0;
    int fb_rise = 0, ref_rise = 0, out_rise = 0;

    localparam int K = 3;
    localparam int NV = 6;
    // Stimulus words {S, M, P} and expected {ref, fb, out} ratios
    localparam logic [15:0] VEC_W [NV] = '{
        {2'd1, 8'd0,   6'd0},
        {2'd2, 8'd17,  6'd3},
        {2'd3, 8'd255, 6'd63},
        {2'd0, 8'd1,   6'd1},
        {2'd1, 8'd100, 6'd40},
        {2'd2, 8'd6,   6'd10}
    };
    localparam int VEC_E [NV][3] = '{
        '{2, 8, 2}, '{5, 25, 4}, '{65, 263, 8},
        '{3, 9, 1}, '{42, 108, 2}, '{12, 14, 4}
    };

    always #10 fast_clk = ~fast_clk;
    always #30 ref_clk  = ~ref_clk;

    always @(posedge fb_div_o)  fb_rise++;
    always @(posedge ref_div_o) ref_rise++;
    always @(posedge clk_out)   out_rise++;

    pll_div_chain uut (
        .fast_clk  (fast_clk),
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .pwr_down  (pwr_down),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .tst_sel   (tst_sel),
        .tst_bits  (tst_bits),
        .ref_div_o (ref_div_o),
        .fb_div_o  (fb_div_o),
        .clk_out   (clk_out)
    );

    task automatic chk_eq(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [15:0] w);
        @(negedge fast_clk);
        cfg_we = 1'b1;
        cfg_wdata = w;
        @(negedge fast_clk);
        cfg_we = 1'b0;
    endtask

    task automatic restart();
        @(negedge fast_clk);
        pwr_down = 1'b0;
        repeat (12) @(posedge fast_clk);
    endtask

    // Fast-domain ratios: rise counts, high counts, output period and duty
    task automatic meas_fast(input string tag, input int n_fb, input int n_out);
        int r0, h;
        realtime t0, t1, t2;
        @(posedge fast_clk); #5;
        r0 = fb_rise; h = 0;
        repeat (n_fb * K) begin
            h += int'(fb_div_o);
            @(posedge fast_clk); #5;
        end
        chk_eq({tag, " R2 fb rises"}, fb_rise - r0, K);
        chk_eq({tag, " R10 fb high cycles"}, h, K * ((n_fb + 1) / 2));
        r0 = out_rise;
        repeat (n_out * 8) @(posedge fast_clk);
        #5;
        chk_eq({tag, " R3 out rises"}, out_rise - r0, 8);
        @(posedge clk_out); t0 = $realtime;
        @(negedge clk_out); t1 = $realtime;
        @(posedge clk_out); t2 = $realtime;
        chk_eq({tag, " R3 out period"}, int'((t2 - t0) / 20.0), n_out);
        n_cmp++;
        if ((t1 - t0) * 100.0 < (t2 - t0) * 40.0 || (t1 - t0) * 100.0 > (t2 - t0) * 60.0) begin
            n_bad++;
            $display("FAIL %s R9 duty: actual %0d expected 50", tag,
                     int'((t1 - t0) * 100.0 / (t2 - t0)));
        end
    endtask

    task automatic meas_ref(input string tag, input int n_ref);
        int r0, h;
        @(posedge ref_clk); #5;
        r0 = ref_rise; h = 0;
        repeat (n_ref * K) begin
            h += int'(ref_div_o);
            @(posedge ref_clk); #5;
        end
        chk_eq({tag, " R1 ref rises"}, ref_rise - r0, K);
        chk_eq({tag, " R10 ref high cycles"}, h, K * ((n_ref + 1) / 2));
    endtask

    initial begin
        #3_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        realtime t0, t1, t2;
        int hi;
        // R5: reset state, outputs low
        repeat (3) @(posedge fast_clk);
        #5;
        chk_eq("R5 reset ref low", int'(ref_div_o), 0);
        chk_eq("R5 reset fb low", int'(fb_div_o), 0);
        chk_eq("R5 reset out low", int'(clk_out), 0);
        @(negedge fast_clk);
        rst_n = 1'b1;
        repeat (12) @(posedge fast_clk);
        meas_ref("R5 cleared word", 2);
        meas_fast("R5 cleared word", 8, 1);

        // R1 R2 R3 R9 R10: vector table
        for (int i = 0; i < NV; i++) begin
            pwr_down = 1'b1;
            wr_cfg(VEC_W[i]);
            repeat (8) @(posedge fast_clk);
            restart();
            meas_ref($sformatf("vec%0d", i), VEC_E[i][0]);
            meas_fast($sformatf("vec%0d", i), VEC_E[i][1], VEC_E[i][2]);
        end

        // R4: data change without strobe is ignored
        @(negedge fast_clk);
        cfg_wdata = {2'd3, 8'd200, 6'd20};
        repeat (20) @(posedge fast_clk);
        meas_ref("R4 no strobe", 12);
        meas_fast("R4 no strobe", 14, 4);

        // R6: test bypass of S and P, M protected
        @(negedge fast_clk);
        pwr_down = 1'b1;
        wr_cfg({2'd1, 8'd17, 6'd3});
        tst_bits = {2'd3, 8'd200, 6'd9};
        tst_sel = 1'b1;
        repeat (8) @(posedge fast_clk);
        restart();
        meas_ref("R6 bypass", 11);
        meas_fast("R6 bypass", 25, 8);
        @(negedge fast_clk);
        pwr_down = 1'b1;
        tst_sel = 1'b0;
        repeat (8) @(posedge fast_clk);
        restart();
        meas_ref("R6 bypass off", 5);
        meas_fast("R6 bypass off", 25, 2);

        // R8: ratio change lands at next reload
        @(posedge fb_div_o); t0 = $realtime;
        wr_cfg({2'd1, 8'd22, 6'd3});
        @(posedge fb_div_o); t1 = $realtime;
        @(posedge fb_div_o); t2 = $realtime;
        chk_eq("R8 old period kept", int'((t1 - t0) / 20.0), 25);
        chk_eq("R8 new period", int'((t2 - t1) / 20.0), 30);

        // R7: power-down with divide-by-one, then clean restart
        pwr_down = 1'b1;
        wr_cfg({2'd0, 8'd1, 6'd1});
        repeat (6) @(posedge fast_clk);
        hi = 0;
        repeat (10) begin
            @(posedge fast_clk); #5;
            hi += int'(fb_div_o) + int'(clk_out);
        end
        chk_eq("R7 fast outputs low", hi, 0);
        hi = 0;
        repeat (10) begin
            @(posedge ref_clk); #5;
            hi += int'(ref_div_o);
        end
        chk_eq("R7 ref output low", hi, 0);
        @(negedge fast_clk);
        pwr_down = 1'b0;
        @(posedge fast_clk); #5;
        chk_eq("R7 edge1 fb", int'(fb_div_o), 0);
        @(posedge fast_clk); #5;
        chk_eq("R7 edge2 fb", int'(fb_div_o), 0);
        @(posedge fast_clk); #5;
        chk_eq("R7 edge3 fb", int'(fb_div_o), 1);
        chk_eq("R7 edge3 out", int'(clk_out), 0);
        @(posedge fast_clk); #5;
        chk_eq("R7 edge4 out", int'(clk_out), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule